// File: doc/BRIEF.md
# Pipeline Hazard Unit

This block is the purely combinational hazard logic of an in-order integer pipeline with five stages (fetch, decode, execute, memory, write-back). Every instruction passes through all five stages, and register writes happen only in write-back, so the only data hazards are read-after-write dependences. The block reads the register indices and control bits held in the decode stage and in the three inter-stage registers behind it. It then drives the operand-bypass selects for the two ALU inputs and the hold, flush and bubble controls for the front of the pipeline.

Most dependences are resolved by forwarding. The execute-stage sources take the memory-stage result or the write-back result in place of the register-file value. The newer of the two wins. Register 0 is never bypassed. There are two cases that forwarding cannot cover. The first is a load in execute whose destination is read by the instruction in decode: that instruction is held for one cycle and a bubble is placed behind the load. The second is a load or store in the memory stage, which occupies the single memory port that fetch also uses. That cycle's fetch is abandoned, the program counter holds, and an empty slot enters the decode register.

Top module: `hazard_unit`

## Requirements
- R1: An execute-stage source index that is nonzero, equals the memory-stage destination and has the memory-stage write enable set gives a select of 2'b10 (bypass from the memory-stage result).
- R2: An execute-stage source that does not match the memory stage under R1, but equals a nonzero write-back destination with the write-back write enable set, gives a select of 2'b01 (bypass from the write-back result).
- R3: When both the memory stage and the write-back stage match the same source, the select is 2'b10.
- R4: Register index 0 never gives a nonzero select, and a load writing register 0 never causes a hold.
- R5: A stage whose write enable is clear never supplies a bypass. With no qualifying producer, the select is 2'b00 (register file).
- R6: Operand A (fwd_a_o, from ex_rs1_i) and operand B (fwd_b_o, from ex_rs2_i) are selected independently under the same rules.
- R7: A load in execute with a nonzero destination equal to either decode source raises pc_hold_o, ifid_hold_o and idex_bubble_o. A non-load instruction in execute with the same destination raises none of them.
- R8: A load or store in the memory stage raises pc_hold_o and ifid_flush_o, and leaves ifid_hold_o and idex_bubble_o low when there is no load-use hazard.
- R9: When R7 and R8 apply in the same cycle, pc_hold_o, ifid_hold_o and idex_bubble_o are high and ifid_flush_o is low, so the held decode instruction is kept.
- R10: With no dependence and no memory access, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | 5 | First source index of the instruction in decode |
| id_rs2_i | input | 5 | Second source index of the instruction in decode |
| ex_rs1_i | input | 5 | First source index held in the decode/execute register |
| ex_rs2_i | input | 5 | Second source index held in the decode/execute register |
| ex_rd_i | input | 5 | Destination index held in the decode/execute register |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | 5 | Destination index held in the execute/memory register |
| mem_we_i | input | 1 | Register write enable in the execute/memory register |
| mem_load_i | input | 1 | Instruction in the memory stage reads data memory |
| mem_store_i | input | 1 | Instruction in the memory stage writes data memory |
| wb_rd_i | input | 5 | Destination index held in the memory/write-back register |
| wb_we_i | input | 1 | Register write enable in the memory/write-back register |
| fwd_a_o | output | 2 | ALU operand A select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_o | output | 2 | ALU operand B select, same encoding |
| pc_hold_o | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged this cycle |
| ifid_flush_o | output | 1 | Load an empty slot into the fetch/decode register |
| idex_bubble_o | output | 1 | Clear register-write and memory-write controls entering execute |

## Verification
The load-use interlock and the memory-port conflict can occur in the same cycle: a load sits in execute with its destination read in decode while an older load or store is in the memory stage. The bench builds this vector directly. It expects the decode register to be held and not flushed, with the program counter held and the execute bubble raised. It also applies each hazard alone, so that a merge that lets the flush override the hold shows up as a mismatch in only the combined case.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } byp_sel_e;

endpackage

// File: rtl/hz_bypass_sel.sv
module hz_bypass_sel
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output byp_sel_e      sel_o
);

  logic src_live, mem_hit, wb_hit;

  assign src_live = |src_i;
  assign mem_hit  = src_live && mem_we_i && (mem_rd_i == src_i);
  assign wb_hit   = src_live && wb_we_i  && (wb_rd_i  == src_i);

  // newest producer wins
  always_comb begin
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic                     ex_load_i,
  input  logic [AW-1:0]            ex_rd_i,
  input  logic [NSRC-1:0][AW-1:0]  id_src_i,
  output logic                     hit_o
);

  logic [NSRC-1:0] src_match;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_match[g] = (id_src_i[g] == ex_rd_i);
  end

  assign hit_o = ex_load_i && (|ex_rd_i) && (|src_match);

endmodule

// File: rtl/hz_stall_merge.sv
module hz_stall_merge (
  input  logic load_use_i,
  input  logic port_busy_i,
  output logic pc_hold_o,
  output logic ifid_hold_o,
  output logic ifid_flush_o,
  output logic idex_bubble_o
);

  always_comb begin
    pc_hold_o     = load_use_i || port_busy_i;
    ifid_hold_o   = load_use_i;
    // a held decode slot must not be overwritten by the fetch bubble
    ifid_flush_o  = port_busy_i && !load_use_i;
    idex_bubble_o = load_use_i;
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  input  logic          mem_store_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          ifid_flush_o,
  output logic          idex_bubble_o
);

  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0][AW-1:0] ex_src;
  logic [NSRC-1:0][AW-1:0] id_src;
  byp_sel_e [NSRC-1:0]     sel;
  logic                    load_use;
  logic                    port_busy;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_byp
    hz_bypass_sel #(.AW(AW)) u_sel (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hz_load_use #(.AW(AW), .NSRC(NSRC)) u_lu (
    .ex_load_i (ex_load_i),
    .ex_rd_i   (ex_rd_i),
    .id_src_i  (id_src),
    .hit_o     (load_use)
  );

  // shared memory port: data access in MEM steals the fetch slot
  assign port_busy = mem_load_i || mem_store_i;

  hz_stall_merge u_merge (
    .load_use_i    (load_use),
    .port_busy_i   (port_busy),
    .pc_hold_o     (pc_hold_o),
    .ifid_hold_o   (ifid_hold_o),
    .ifid_flush_o  (ifid_flush_o),
    .idex_bubble_o (idex_bubble_o)
  );

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] ex_rs2_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic          mem_load_i,
  input logic          mem_store_i,
  input logic [AW-1:0] wb_rd_i,
  input logic          wb_we_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          pc_hold_o,
  input logic          ifid_hold_o,
  input logic          ifid_flush_o,
  input logic          idex_bubble_o
);

  always_comb begin
    // R3
    if (mem_we_i && (|ex_rs1_i) && mem_rd_i == ex_rs1_i)
      byp_prio_a_chk: assert (fwd_a_o == 2'b10);
    // R6
    if (mem_we_i && (|ex_rs2_i) && mem_rd_i == ex_rs2_i)
      byp_prio_b_chk: assert (fwd_b_o == 2'b10);
    // R4
    if (ex_rs1_i == '0)
      zero_reg_a_chk: assert (fwd_a_o == 2'b00);
    // R2
    if (fwd_a_o == 2'b01)
      wb_src_a_chk: assert (wb_we_i && wb_rd_i == ex_rs1_i);
    // R7
    if (idex_bubble_o)
      lu_hold_chk: assert (pc_hold_o && ifid_hold_o);
    // R8
    if (mem_load_i || mem_store_i)
      port_hold_chk: assert (pc_hold_o);
    // R9
    hold_flush_excl_chk: assert (!(ifid_hold_o && ifid_flush_o));
  end

endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (
  .ex_rs1_i      (ex_rs1_i),
  .ex_rs2_i      (ex_rs2_i),
  .mem_rd_i      (mem_rd_i),
  .mem_we_i      (mem_we_i),
  .mem_load_i    (mem_load_i),
  .mem_store_i   (mem_store_i),
  .wb_rd_i       (wb_rd_i),
  .wb_we_i       (wb_we_i),
  .fwd_a_o       (fwd_a_o),
  .fwd_b_o       (fwd_b_o),
  .pc_hold_o     (pc_hold_o),
  .ifid_hold_o   (ifid_hold_o),
  .ifid_flush_o  (ifid_flush_o),
  .idex_bubble_o (idex_bubble_o)
);

// File: tb/tb_hazard_unit.sv
`timescale 1ns/100ps
module tb_hazard_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_load, mem_we, mem_load, mem_store, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ifid_flush, idex_bubble;

  hazard_unit dut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .ex_rd_i(ex_rd), .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .mem_load_i(mem_load), .mem_store_i(mem_store), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .ifid_flush_o(ifid_flush), .idex_bubble_o(idex_bubble)
  );

  typedef struct {
    logic [1:0] fa, fb;
    logic pc, hold, flush, bub;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic idle_in();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_load = 0; mem_we = 0; mem_load = 0; mem_store = 0; wb_we = 0;
  endtask

  // inputs already set by caller; push the expectation for this cycle
  task automatic push(input logic [1:0] fa, input logic [1:0] fb, input logic pc,
                      input logic hold, input logic flush, input logic bub, input string req);
    exp_t e;
    e.fa = fa; e.fb = fb; e.pc = pc; e.hold = hold; e.flush = flush; e.bub = bub; e.req = req;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if ({fwd_a, fwd_b, pc_hold, ifid_hold, ifid_flush, idex_bubble} !==
          {e.fa, e.fb, e.pc, e.hold, e.flush, e.bub}) begin
        n_fail++;
        $display("FAIL %s: got fa=%b fb=%b pc=%b hold=%b flush=%b bub=%b exp fa=%b fb=%b pc=%b hold=%b flush=%b bub=%b",
                 e.req, fwd_a, fwd_b, pc_hold, ifid_hold, ifid_flush, idex_bubble,
                 e.fa, e.fb, e.pc, e.hold, e.flush, e.bub);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_in();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    // R10 idle state
    idle_in(); push(2'b00, 2'b00, 0, 0, 0, 0, "R10");
    // R1 memory-stage bypass
    idle_in(); mem_we = 1; mem_rd = 3; ex_rs1 = 3; push(2'b10, 2'b00, 0, 0, 0, 0, "R1");
    // R2 write-back bypass
    idle_in(); wb_we = 1; wb_rd = 7; ex_rs1 = 7; mem_we = 1; mem_rd = 8;
    push(2'b01, 2'b00, 0, 0, 0, 0, "R2");
    // R3 both match
    idle_in(); mem_we = 1; mem_rd = 4; wb_we = 1; wb_rd = 4; ex_rs1 = 4; ex_rs2 = 4;
    push(2'b10, 2'b10, 0, 0, 0, 0, "R3");
    // R4 register zero
    idle_in(); mem_we = 1; wb_we = 1; ex_load = 1; push(2'b00, 2'b00, 0, 0, 0, 0, "R4");
    // R5 write enable clear
    idle_in(); mem_rd = 5; wb_rd = 5; ex_rs1 = 5; ex_rs2 = 5;
    push(2'b00, 2'b00, 0, 0, 0, 0, "R5");
    // R6 independent operands
    idle_in(); ex_rs1 = 2; ex_rs2 = 9; wb_we = 1; wb_rd = 2; mem_we = 1; mem_rd = 9;
    push(2'b01, 2'b10, 0, 0, 0, 0, "R6");
    idle_in(); ex_rs2 = 11; wb_we = 1; wb_rd = 11; push(2'b00, 2'b01, 0, 0, 0, 0, "R6");
    // R7 load-use on either source
    idle_in(); ex_load = 1; ex_rd = 6; id_rs2 = 6; push(2'b00, 2'b00, 1, 1, 0, 1, "R7");
    idle_in(); ex_load = 1; ex_rd = 12; id_rs1 = 12; push(2'b00, 2'b00, 1, 1, 0, 1, "R7");
    idle_in(); ex_rd = 6; id_rs1 = 6; push(2'b00, 2'b00, 0, 0, 0, 0, "R7");
    idle_in(); ex_load = 1; ex_rd = 6; id_rs1 = 1; id_rs2 = 2;
    push(2'b00, 2'b00, 0, 0, 0, 0, "R7");
    // R8 memory port taken
    idle_in(); mem_load = 1; push(2'b00, 2'b00, 1, 0, 1, 0, "R8");
    idle_in(); mem_store = 1; mem_rd = 3; ex_rs1 = 3; push(2'b00, 2'b00, 1, 0, 1, 0, "R8");
    // R9 both stalls together, plus a bypass from a load result
    idle_in(); mem_load = 1; mem_we = 1; mem_rd = 10; ex_rs2 = 10;
    ex_load = 1; ex_rd = 13; id_rs1 = 13; push(2'b00, 2'b10, 1, 1, 0, 1, "R9");
    idle_in(); push(2'b00, 2'b00, 0, 0, 0, 0, "R10");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule